// File: doc/BRIEF.md
# Power-On and System Reset Sequencer

This block turns one active-low power-on reset pin into the reset outputs of a small system-on-chip. While power-on reset is held, it samples the configuration strap pins into a register, keeps every PLL output-enable off, holds the CPU in reset and drives a clear pulse to the sticky register bits of the watchdog and high-resolution timers. When the pin is released, it passes through a two-stage synchronizer. The released state then starts two processes. One brings up the PLL output-enables one at a time as each PLL reports lock, and the third enable is always the last. The other counts a programmable number of reference-clock cycles before the CPU reset is dropped.

The peripheral-bus reset (active low) is driven by every system reset. There are three sources: power-on reset, a one-cycle watchdog reset pulse and a software reset request. A watchdog or software request is a warm reset. It holds the bus reset low for a minimum number of cycles. A new request during that window restarts the count and does not start a new sequence. A two-bit cause register records the source that started the most recent system reset. Only power-on reset clears it.

Top module: `rst_sequencer`

## Requirements
- R1: While power-on reset is active (including the two synchronizer cycles after `por_n` rises), `strap_q` loads `strap_in` on every clock. After that it holds its value until the next power-on reset.
- R2: While `por_n` is low, all bits of `pll_en` are 0 whatever `pll_lock` is, and they go to 0 as soon as `por_n` falls.
- R3: After release, `pll_en[i]` rises on the clock edge after one where `pll_lock[i]` is 1 and, for i > 0, `pll_en[i-1]` is already 1. PLL 0 comes up first, then 1, then 2, so `pll_en[2]` is always the last. Once set, an enable stays set until power-on reset.
- R4: `por_n` going low resets all outputs at once, without waiting for a clock. The rising edge of `por_n` takes effect two clock edges later (the release point).
- R5: `bus_rst_n` is 0 from power-on reset up to the release point and rises in the same cycle that `sticky_clr` falls.
- R6: A watchdog pulse or software request sampled at a clock edge after the release point drives `bus_rst_n` low from the next cycle. It stays low for exactly MIN_W cycles (default 16) counted from the last edge that sampled a request.
- R7: A request that arrives while a warm bus reset is running restarts the MIN_W count and leaves `rst_cause` unchanged.
- R8: `cpu_rst` is 1 during power-on reset and falls exactly CPU_HOLD cycles after the release point. Warm resets never raise it.
- R9: `sticky_clr` is 1 only from power-on reset up to the release point. Warm resets leave it at 0.
- R10: `rst_cause` encoding is 2'b00 for power-on, 2'b01 for watchdog and 2'b10 for software. Power-on reset sets 2'b00. A warm reset that starts from idle writes its source in the cycle after the request, and watchdog wins when both sources request in the same cycle.
- R11: A warm reset changes neither `strap_q` nor `pll_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| strap_in | input | STRAP_W | Configuration strap pins |
| pll_lock | input | NUM_PLL | Lock indication from each PLL |
| wdog_rst | input | 1 | Watchdog reset event pulse |
| sw_rst_req | input | 1 | Software system-reset request |
| strap_q | output | STRAP_W | Captured strap value |
| pll_en | output | NUM_PLL | PLL clock output-enables |
| bus_rst_n | output | 1 | Peripheral-bus reset, active low |
| cpu_rst | output | 1 | CPU reset, active high |
| sticky_clr | output | 1 | Clear for the timers' sticky register bits |
| rst_cause | output | 2 | Source of the last system reset |

## Verification
The asynchronous effects of `por_n` going low are checked one nanosecond after the pin is driven, with no clock edge in between. Every other result is due a fixed number of edges after its stimulus:
- the release point two edges after `por_n` rises;
- a PLL enable one edge after the enable condition holds;
- the bus reset one edge after a request, and back high MIN_W edges after the last request;
- the CPU reset falling CPU_HOLD edges after the release point.

At the moment of each stimulus, the driver computes the due cycle of every result from these latencies and queues it. The monitor compares each queued value on the falling clock edge of exactly that cycle. Checks also fall on the last cycle before a change, so an off-by-one error in any counter shows.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'b00,
        CAUSE_WDOG = 2'b01,
        CAUSE_SW   = 2'b10
    } rst_cause_e;

    // Watchdog outranks software when both ask in the same cycle.
    function automatic rst_cause_e pick_cause(input logic wd, input logic sw);
        if (wd)
            return CAUSE_WDOG;
        else if (sw)
            return CAUSE_SW;
        else
            return CAUSE_POR;
    endfunction

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned count_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstseq_por_sync.sv
module rstseq_por_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic released
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            shift_q <= '0;
        else
            shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign released = shift_q[STAGES-1];
endmodule

// File: rtl/rstseq_pll_chain.sv
module rstseq_pll_chain #(
    parameter int unsigned NUM_PLL = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               released,
    input  logic [NUM_PLL-1:0] lock,
    output logic [NUM_PLL-1:0] enable
);
    // gate[i] is the permission from the PLL below: the first one is free.
    logic [NUM_PLL-1:0] gate;

    generate
        for (genvar i = 0; i < NUM_PLL; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign gate[i] = 1'b1;
            end else begin : g_next
                assign gate[i] = enable[i-1];
            end

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n)
                    enable[i] <= 1'b0;
                else if (released && lock[i] && gate[i])
                    enable[i] <= 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/rstseq_cpu_hold.sv
module rstseq_cpu_hold
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD = 3300
) (
    input  logic clk,
    input  logic por_n,
    input  logic released,
    output logic hold
);
    localparam int unsigned CW = count_w(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold  <= 1'b1;
            cnt_q <= '0;
        end else if (released && hold) begin
            if (cnt_q == LAST)
                hold <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_warm_timer.sv
module rstseq_warm_timer
    import rstseq_pkg::*;
#(
    parameter int unsigned MIN_W = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       released,
    input  logic       wd_req,
    input  logic       sw_req,
    output logic       busy,
    output rst_cause_e cause
);
    localparam int unsigned CW = count_w(MIN_W);
    localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

    logic [CW-1:0] cnt_q;
    logic          req;

    assign req = released && (wd_req || sw_req);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            cause <= CAUSE_POR;
        end else if (req) begin
            // A request during a running window only restarts the count.
            if (!busy)
                cause <= pick_cause(wd_req, sw_req);
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST)
                busy <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned NUM_PLL     = 3,
    parameter int unsigned STRAP_W     = 8,
    parameter int unsigned CPU_HOLD    = 3300,
    parameter int unsigned MIN_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic [NUM_PLL-1:0] pll_lock,
    input  logic               wdog_rst,
    input  logic               sw_rst_req,
    output logic [STRAP_W-1:0] strap_q,
    output logic [NUM_PLL-1:0] pll_en,
    output logic               bus_rst_n,
    output logic               cpu_rst,
    output logic               sticky_clr,
    output logic [1:0]         rst_cause
);
    logic       released;
    logic       warm_busy;
    rst_cause_e cause;

    rstseq_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .released (released)
    );

    // Straps follow the pins until the release point, then freeze.
    always_ff @(posedge clk) begin
        if (!released)
            strap_q <= strap_in;
    end

    rstseq_pll_chain #(.NUM_PLL(NUM_PLL)) u_pll (
        .clk      (clk),
        .por_n    (por_n),
        .released (released),
        .lock     (pll_lock),
        .enable   (pll_en)
    );

    rstseq_cpu_hold #(.HOLD(CPU_HOLD)) u_cpu (
        .clk      (clk),
        .por_n    (por_n),
        .released (released),
        .hold     (cpu_rst)
    );

    rstseq_warm_timer #(.MIN_W(MIN_W)) u_warm (
        .clk      (clk),
        .por_n    (por_n),
        .released (released),
        .wd_req   (wdog_rst),
        .sw_req   (sw_rst_req),
        .busy     (warm_busy),
        .cause    (cause)
    );

    assign bus_rst_n  = released && !warm_busy;
    assign sticky_clr = !released;
    assign rst_cause  = cause;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int unsigned NUM_PLL = 3,
    parameter int unsigned STRAP_W = 8
) (
    input logic               clk,
    input logic               por_n,
    input logic [NUM_PLL-1:0] pll_lock,
    input logic               wdog_rst,
    input logic               sw_rst_req,
    input logic [STRAP_W-1:0] strap_q,
    input logic [NUM_PLL-1:0] pll_en,
    input logic               bus_rst_n,
    input logic               cpu_rst,
    input logic               sticky_clr,
    input logic [1:0]         rst_cause
);
    generate
        for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
            assert_pll_lock_R3: assert property (@(posedge clk) disable iff (!por_n)
                $rose(pll_en[i]) |-> $past(pll_lock[i]));
            if (i > 0) begin : g_order
                assert_pll_order_R3: assert property (@(posedge clk) disable iff (!por_n)
                    $rose(pll_en[i]) |-> $past(pll_en[i-1]));
            end
        end
    endgenerate

    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (!por_n)
        !sticky_clr |=> $stable(strap_q));

    assert_bus_during_por_R5: assert property (@(posedge clk) disable iff (!por_n)
        sticky_clr |-> !bus_rst_n);

    assert_warm_bus_R6: assert property (@(posedge clk) disable iff (!por_n)
        (wdog_rst || sw_rst_req) |=> !bus_rst_n);

    assert_cpu_stays_low_R8: assert property (@(posedge clk) disable iff (!por_n)
        !cpu_rst |=> !cpu_rst);

    assert_warm_no_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
        ((wdog_rst || sw_rst_req) && !sticky_clr) |=> !sticky_clr);

    assert_cause_from_idle_R10: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(rst_cause) |-> $past(bus_rst_n));
endmodule

bind rst_sequencer rst_sequencer_chk #(.NUM_PLL(NUM_PLL), .STRAP_W(STRAP_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .pll_lock   (pll_lock),
    .wdog_rst   (wdog_rst),
    .sw_rst_req (sw_rst_req),
    .strap_q    (strap_q),
    .pll_en     (pll_en),
    .bus_rst_n  (bus_rst_n),
    .cpu_rst    (cpu_rst),
    .sticky_clr (sticky_clr),
    .rst_cause  (rst_cause)
);

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;
    localparam int HOLD  = 48;
    localparam int MINW  = 16;
    localparam int SW    = 4;

    localparam int S_STRAP = 0, S_PLL = 1, S_BUS = 2, S_CPU = 3, S_CLR = 4, S_CAUSE = 5;

    logic          clk = 1'b0;
    logic          por_n = 1'b1;
    logic [SW-1:0] strap_in = 4'hA;
    logic [2:0]    pll_lock = 3'b111;
    logic          wdog_rst = 1'b0;
    logic          sw_rst_req = 1'b0;
    logic [SW-1:0] strap_q;
    logic [2:0]    pll_en;
    logic          bus_rst_n, cpu_rst, sticky_clr;
    logic [1:0]    rst_cause;

    rst_sequencer #(.NUM_PLL(3), .STRAP_W(SW), .CPU_HOLD(HOLD), .MIN_W(MINW)) dut (
        .clk(clk), .por_n(por_n), .strap_in(strap_in), .pll_lock(pll_lock),
        .wdog_rst(wdog_rst), .sw_rst_req(sw_rst_req), .strap_q(strap_q),
        .pll_en(pll_en), .bus_rst_n(bus_rst_n), .cpu_rst(cpu_rst),
        .sticky_clr(sticky_clr), .rst_cause(rst_cause)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    due;
        int    sig;
        int    exp;
        string req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample(input int s);
        case (s)
            S_STRAP: return int'(strap_q);
            S_PLL:   return int'(pll_en);
            S_BUS:   return int'(bus_rst_n);
            S_CPU:   return int'(cpu_rst);
            S_CLR:   return int'(sticky_clr);
            default: return int'(rst_cause);
        endcase
    endfunction

    function automatic string sname(input int s);
        case (s)
            S_STRAP: return "strap_q";
            S_PLL:   return "pll_en";
            S_BUS:   return "bus_rst_n";
            S_CPU:   return "cpu_rst";
            S_CLR:   return "sticky_clr";
            default: return "rst_cause";
        endcase
    endfunction

    task automatic check(input int s, input int e, input string r);
        int a;
        a = sample(s);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", r, sname(s), cyc, a, e);
        end
    endtask

    // Driver side: queue a value due d clock edges from now.
    task automatic expect_in(input int d, input int s, input int e, input string r);
        sb.push_back('{cyc + d, s, e, r});
    endtask

    // Monitor: compare every queued item on the falling edge of its cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                check(sb[i].sig, sb[i].exp, sb[i].req);
                sb.delete(i);
            end
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic pulse_req(input logic wd, input logic sw, input int len);
        wdog_rst = wd;
        sw_rst_req = sw;
        step(len);
        wdog_rst = 1'b0;
        sw_rst_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        #1 por_n = 1'b0;
        #1;
        check(S_PLL, 0, "R2");
        check(S_CPU, 1, "R4");
        step(4);
        check(S_PLL, 0, "R2");
        check(S_BUS, 0, "R5");
        check(S_CPU, 1, "R8");
        check(S_CLR, 1, "R9");
        check(S_CAUSE, 0, "R10");
        check(S_STRAP, 32'hA, "R1");

        // Release: straps switch to 5, locks drop.
        strap_in = 4'h5;
        pll_lock = 3'b000;
        step(1);
        por_n = 1'b1;
        expect_in(1, S_CLR, 1, "R4");
        expect_in(1, S_BUS, 0, "R5");
        expect_in(2, S_CLR, 0, "R4");
        expect_in(2, S_BUS, 1, "R5");
        expect_in(HOLD + 1, S_CPU, 1, "R8");
        expect_in(HOLD + 2, S_CPU, 0, "R8");
        step(2);
        strap_in = 4'h3;
        expect_in(2, S_STRAP, 5, "R1");

        // Third PLL locks first: it must wait for the others.
        pll_lock = 3'b100;
        expect_in(1, S_PLL, 0, "R3");
        expect_in(3, S_PLL, 0, "R3");
        step(3);
        pll_lock = 3'b101;
        expect_in(1, S_PLL, 1, "R3");
        expect_in(2, S_PLL, 1, "R3");
        step(2);
        pll_lock = 3'b111;
        expect_in(1, S_PLL, 3, "R3");
        expect_in(2, S_PLL, 7, "R3");
        step(HOLD + 3);

        // Single watchdog pulse.
        expect_in(1, S_BUS, 0, "R6");
        expect_in(1, S_CAUSE, 1, "R10");
        expect_in(1, S_CLR, 0, "R9");
        expect_in(MINW, S_BUS, 0, "R6");
        expect_in(MINW + 1, S_BUS, 1, "R6");
        expect_in(2, S_CPU, 0, "R8");
        expect_in(2, S_PLL, 7, "R11");
        expect_in(2, S_STRAP, 5, "R11");
        pulse_req(1'b1, 1'b0, 1);
        step(20);

        // Single software request.
        expect_in(1, S_CAUSE, 2, "R10");
        expect_in(1, S_BUS, 0, "R6");
        expect_in(MINW + 1, S_BUS, 1, "R6");
        pulse_req(1'b0, 1'b1, 1);
        step(20);

        // Watchdog, then a software request inside the window.
        expect_in(1, S_CAUSE, 1, "R7");
        expect_in(MINW + 1, S_BUS, 0, "R7");
        expect_in(4 + MINW, S_BUS, 0, "R7");
        expect_in(4 + MINW + 1, S_BUS, 1, "R7");
        expect_in(6, S_CAUSE, 1, "R7");
        pulse_req(1'b1, 1'b0, 1);
        step(3);
        pulse_req(1'b0, 1'b1, 1);
        step(25);

        // Both sources together: watchdog wins.
        expect_in(1, S_CAUSE, 1, "R10");
        pulse_req(1'b1, 1'b1, 1);
        step(20);

        // Software request held for five cycles.
        expect_in(1, S_CAUSE, 2, "R10");
        expect_in(MINW + 4, S_BUS, 0, "R6");
        expect_in(MINW + 5, S_BUS, 1, "R6");
        pulse_req(1'b0, 1'b1, 5);
        step(25);

        // Second power-on reset, asserted between clock edges.
        por_n = 1'b0;
        #1;
        check(S_PLL, 0, "R2");
        check(S_BUS, 0, "R4");
        check(S_CPU, 1, "R4");
        check(S_CLR, 1, "R9");
        check(S_CAUSE, 0, "R10");
        step(3);
        por_n = 1'b1;
        expect_in(2, S_BUS, 1, "R5");
        expect_in(3, S_PLL, 1, "R3");
        expect_in(5, S_PLL, 7, "R3");
        step(10);
        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule